// File: doc/BRIEF.md
# Host Bridge Shadow-Memory Configuration Registers

This block is the configuration byte space of a host bridge. It holds 256 bytes at one PCI function, with one byte-wide write port and one byte-wide read port. Each port carries a function number and a register offset. Most bytes are plain storage. A few are identification constants, one command byte has a single writable bit, and one status byte has bits that are cleared by writing a 1.

The main job of the block is to turn three shadow-control bytes into routing signals for the upper memory area. Below one megabyte that area is split into eight 16 KB segments from C0000 to DFFFF and two 64 KB segments at E0000 and F0000. For each segment the block drives two outputs. One says whether reads of that segment are served by internal memory. The other says the same for writes. A separate output flags that the system firmware area at F0000 is being read from its shadow copy.

A warm-reset input models a bus reset. It turns off shadow reads and writes of the F0000 segment and leaves every other byte alone. The active-low `rst_n` loads every default.

Top module: `hb_shadow_cfg`

## Requirements
- R1: Writes to offsets 0x00, 0x01, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0E and 0x0F change nothing. After reset these read 0x34, 0x12, 0x02, 0x00, 0x00, 0x06, 0x00, 0x00 and 0x00.
- R2: At offset 0x04 only bit 6 takes the written value and the other seven bits keep their value. The reset value is 0x07.
- R3: Offset 0x07 resets to 0x02. Writing a 1 to bit 7, 5 or 4 clears that bit, and writing 0 leaves it unchanged. Bits 6 and 3:0 ignore writes. A pulse on `stat_evt[0]`, `stat_evt[1]` or `stat_evt[2]` sets bit 4, 5 or 7 respectively, and a set wins over a clear in the same cycle.
- R4: Each 2-bit shadow code `c` drives its segment's read-internal output from `c[1]` and its write-internal output from `c[0]`. So code 0 is external/external, 1 is read external and write internal, 2 is read internal and write external, and 3 is internal/internal.
- R5: Segment index `s` (0..7) takes bits `[2*(s%4)+1 : 2*(s%4)]` of offset 0x61 for s < 4 and of offset 0x62 for s >= 4. Segments 0..7 are C0000, C4000, ..., DC000. Index 8 (E0000) takes bits 7:6 of offset 0x63, and index 9 (F0000) takes bits 5:4 of 0x63.
- R6: Routing outputs are registered. They still show the old value in the cycle after the writing clock edge and show the new value from the following edge on. After `rst_n` every routing output is 0.
- R7: `bios_shadow` equals bit 5 of offset 0x63 as of the previous clock edge, which means reads of F0000 are internal.
- R8: A `warm_rst` pulse clears bits 5:4 of offset 0x63 and leaves every other bit of every byte unchanged. It wins over a write to 0x63 in the same cycle.
- R9: A read with a nonzero function number returns 0xFF.
- R10: A write with a nonzero function number is discarded.
- R11: Reset values are 0x52=0x02, 0x58=0x40, 0x59=0x05, 0x5A..0x5F=0x01 and 0x64=0xAB, and every other offset not covered by R1 to R3 is 0x00. All those other offsets store a written byte in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads all defaults |
| warm_rst | input | 1 | Bus-reset pulse; clears the F0000 shadow field |
| wr_en | input | 1 | Write strobe |
| wr_func | input | 3 | Function number of the write |
| wr_addr | input | 8 | Register offset of the write |
| wr_data | input | 8 | Write byte |
| stat_evt | input | 3 | Status set events for bits 4, 5, 7 of offset 0x07 |
| rd_func | input | 3 | Function number of the read |
| rd_addr | input | 8 | Register offset of the read |
| rd_data | output | 8 | Combinational read byte |
| seg_rd_int | output | 10 | Per-segment read-internal flags, index as in R5 |
| seg_wr_int | output | 10 | Per-segment write-internal flags, index as in R5 |
| bios_shadow | output | 1 | Firmware area at F0000 is read from shadow |

## Verification
The bench sweeps all 256 values through each of the three shadow bytes and checks every segment output. A swapped code bit or a shifted field would turn some segment's read and write flags around, or move them onto a neighbouring segment. It also writes two complementary patterns to every offset and reads them back. This catches a read-only byte that takes a write, a command byte that stores more than bit 6, and a status byte that stores data where it should clear. Targeted cases cover three further faults. A design that misses the one-cycle routing lag would show the new routing one cycle early. A warm reset that wipes the whole byte 0x63 would lose the E0000 field. A design that lets a clear win over a same-cycle set event would drop the status bit.

// File: rtl/hb_shadow_pkg.sv
package hb_shadow_pkg;

   localparam int unsigned BYTE_W = 8;

   localparam int unsigned OFS_CMD  = 'h04;
   localparam int unsigned OFS_STAT = 'h07;

   typedef enum logic [1:0] {
      ROUTE_EXT      = 2'd0,
      ROUTE_WR_INT   = 2'd1,
      ROUTE_RD_INT   = 2'd2,
      ROUTE_BOTH_INT = 2'd3
   } route_code_e;

   typedef struct packed {
      logic rd_int;
      logic wr_int;
   } seg_route_t;

   function automatic seg_route_t decode_code(input logic [1:0] code);
      seg_route_t r;
      case (route_code_e'(code))
         ROUTE_EXT:      r = '{rd_int: 1'b0, wr_int: 1'b0};
         ROUTE_WR_INT:   r = '{rd_int: 1'b0, wr_int: 1'b1};
         ROUTE_RD_INT:   r = '{rd_int: 1'b1, wr_int: 1'b0};
         default:        r = '{rd_int: 1'b1, wr_int: 1'b1};
      endcase
      return r;
   endfunction

   function automatic bit is_read_only(input int unsigned a);
      return (a == 'h00) || (a == 'h01) || ((a >= 'h08) && (a <= 'h0C)) ||
             (a == 'h0E) || (a == 'h0F);
   endfunction

   function automatic logic [BYTE_W-1:0] write_mask(input int unsigned a);
      if (is_read_only(a))   return 8'h00;
      if (a == OFS_CMD)      return 8'h40;
      if (a == OFS_STAT)     return 8'h00;
      return 8'hFF;
   endfunction

   function automatic logic [BYTE_W-1:0] clear_mask(input int unsigned a);
      return (a == OFS_STAT) ? 8'hB0 : 8'h00;
   endfunction

   function automatic logic [BYTE_W-1:0] set_mask(input int unsigned a);
      return (a == OFS_STAT) ? 8'hB0 : 8'h00;
   endfunction

   function automatic logic [BYTE_W-1:0] reset_value(input int unsigned a,
                                                     input logic [15:0] vid,
                                                     input logic [7:0]  rev,
                                                     input logic [7:0]  cls);
      if (a == 'h00)                   return vid[7:0];
      if (a == 'h01)                   return vid[15:8];
      if (a == OFS_CMD)                return 8'h07;
      if (a == OFS_STAT)               return 8'h02;
      if (a == 'h08)                   return rev;
      if (a == 'h0B)                   return cls;
      if (a == 'h52)                   return 8'h02;
      if (a == 'h58)                   return 8'h40;
      if (a == 'h59)                   return 8'h05;
      if ((a >= 'h5A) && (a <= 'h5F))  return 8'h01;
      if (a == 'h64)                   return 8'hAB;
      return 8'h00;
   endfunction

endpackage

// File: rtl/hb_cfg_cell.sv
module hb_cfg_cell #(
   parameter int unsigned W         = 8,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter logic [W-1:0] WR_MASK   = '1,
   parameter logic [W-1:0] CLR_MASK  = '0,
   parameter logic [W-1:0] SET_MASK  = '0,
   parameter logic [W-1:0] WARM_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         warm_rst,
   input  logic         we,
   input  logic [W-1:0] wd,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] q
);

   localparam bit IS_CONST = (WR_MASK == '0) && (CLR_MASK == '0) &&
                             (SET_MASK == '0) && (WARM_MASK == '0);

   generate
      if (IS_CONST) begin : g_const
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, warm_rst, we, wd, set_bits};
         assign q = RST_VAL;
      end else begin : g_store
         logic [W-1:0] q_r;
         logic [W-1:0] nxt;

         always_comb begin
            nxt = q_r;
            if (we) begin
               nxt = (q_r & ~WR_MASK) | (wd & WR_MASK);
               nxt = nxt & ~(wd & CLR_MASK);
            end
            nxt = nxt | (set_bits & SET_MASK);
            if (warm_rst) begin
               nxt = nxt & ~WARM_MASK;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r <= RST_VAL;
            end else begin
               q_r <= nxt;
            end
         end

         assign q = q_r;
      end
   endgenerate

endmodule

// File: rtl/hb_shadow_route.sv
module hb_shadow_route
   import hb_shadow_pkg::*;
#(
   parameter int unsigned SEG16_COUNT = 8,
   localparam int unsigned NUM_SEG    = SEG16_COUNT + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2*SEG16_COUNT-1:0] small_codes,
   input  logic [1:0]               e_code,
   input  logic [1:0]               f_code,
   output logic [NUM_SEG-1:0]       seg_rd_int,
   output logic [NUM_SEG-1:0]       seg_wr_int,
   output logic                     bios_shadow
);

   logic [2*NUM_SEG-1:0] all_codes;
   assign all_codes = {f_code, e_code, small_codes};

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         seg_route_t dec;
         assign dec = decode_code(all_codes[2*s +: 2]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seg_rd_int[s] <= 1'b0;
               seg_wr_int[s] <= 1'b0;
            end else begin
               seg_rd_int[s] <= dec.rd_int;
               seg_wr_int[s] <= dec.wr_int;
            end
         end
      end
   endgenerate

   seg_route_t f_dec;
   assign f_dec = decode_code(f_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bios_shadow <= 1'b0;
      end else begin
         bios_shadow <= f_dec.rd_int;
      end
   end

endmodule

// File: rtl/hb_shadow_cfg.sv
module hb_shadow_cfg
   import hb_shadow_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 256,
   parameter int unsigned FUNC_W      = 3,
   parameter int unsigned SEG16_COUNT = 8,
   parameter int unsigned SHADOW_BASE = 'h61,
   parameter logic [15:0] DEV_VID     = 16'h1234,
   parameter logic [7:0]  DEV_REV     = 8'h02,
   parameter logic [7:0]  DEV_CLASS   = 8'h06,
   localparam int unsigned ADDR_W     = $clog2(NUM_REGS),
   localparam int unsigned NUM_SEG    = SEG16_COUNT + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                warm_rst,
   input  logic                wr_en,
   input  logic [FUNC_W-1:0]   wr_func,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic [2:0]          stat_evt,
   input  logic [FUNC_W-1:0]   rd_func,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [BYTE_W-1:0]   rd_data,
   output logic [NUM_SEG-1:0]  seg_rd_int,
   output logic [NUM_SEG-1:0]  seg_wr_int,
   output logic                bios_shadow
);

   localparam int unsigned SMALL_BYTES = SEG16_COUNT / 4;
   localparam int unsigned TOP_BYTE    = SHADOW_BASE + SMALL_BYTES;

   generate
      if (NUM_REGS != (1 << ADDR_W)) begin : g_bad_depth
         $error("NUM_REGS must be a power of two");
      end
      if (NUM_REGS < 128) begin : g_bad_small
         $error("NUM_REGS too small for the defined offsets");
      end
      if ((SEG16_COUNT % 4) != 0 || SEG16_COUNT == 0) begin : g_bad_seg
         $error("SEG16_COUNT must be a nonzero multiple of four");
      end
      if (TOP_BYTE >= NUM_REGS) begin : g_bad_base
         $error("shadow bytes fall outside the register space");
      end
   endgenerate

   logic                wr_hit;
   logic [BYTE_W-1:0]   stat_set;
   logic [BYTE_W-1:0]   cfg_q [NUM_REGS];

   assign wr_hit   = wr_en && (wr_func == '0);
   assign stat_set = {stat_evt[2], 1'b0, stat_evt[1], stat_evt[0], 4'b0000};

   generate
      for (genvar a = 0; a < NUM_REGS; a++) begin : g_byte
         localparam logic [BYTE_W-1:0] RV = reset_value(a, DEV_VID, DEV_REV, DEV_CLASS);
         localparam logic [BYTE_W-1:0] WM = write_mask(a);
         localparam logic [BYTE_W-1:0] CM = clear_mask(a);
         localparam logic [BYTE_W-1:0] SM = set_mask(a);
         localparam logic [BYTE_W-1:0] XM = (a == TOP_BYTE) ? 8'h30 : 8'h00;

         hb_cfg_cell #(
            .W         (BYTE_W),
            .RST_VAL   (RV),
            .WR_MASK   (WM),
            .CLR_MASK  (CM),
            .SET_MASK  (SM),
            .WARM_MASK (XM)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .warm_rst (warm_rst),
            .we       (wr_hit && (wr_addr == ADDR_W'(a))),
            .wd       (wr_data),
            .set_bits ((a == OFS_STAT) ? stat_set : 8'h00),
            .q        (cfg_q[a])
         );
      end
   endgenerate

   assign rd_data = (rd_func == '0) ? cfg_q[rd_addr] : 8'hFF;

   logic [2*SEG16_COUNT-1:0] small_codes;

   generate
      for (genvar k = 0; k < SMALL_BYTES; k++) begin : g_small
         assign small_codes[8*k +: 8] = cfg_q[SHADOW_BASE + k];
      end
   endgenerate

   hb_shadow_route #(
      .SEG16_COUNT (SEG16_COUNT)
   ) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .small_codes (small_codes),
      .e_code      (cfg_q[TOP_BYTE][7:6]),
      .f_code      (cfg_q[TOP_BYTE][5:4]),
      .seg_rd_int  (seg_rd_int),
      .seg_wr_int  (seg_wr_int),
      .bios_shadow (bios_shadow)
   );

endmodule

// File: rtl/hb_shadow_cfg_chk.sv
module hb_shadow_cfg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       warm_rst,
   input logic       wr_en,
   input logic [2:0] wr_func,
   input logic [7:0] wr_addr,
   input logic       wr_d7,
   input logic       evt7,
   input logic [2:0] rd_func,
   input logic [7:0] rd_data,
   input logic [7:0] b_cmd,
   input logic       b_stat7,
   input logic [1:0] b61_lo,
   input logic [1:0] b63_f,
   input logic       seg_rd0,
   input logic       seg_wr0,
   input logic       seg_rd_f,
   input logic       bios_shadow
);

   // R2: only bit 6 of the command byte may change on a write
   assert_cmd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_func == 3'd0 && wr_addr == 8'h04)
      |=> ((b_cmd & 8'hBF) == ($past(b_cmd) & 8'hBF)));

   // R3: write-one clears status bit 7 when no set event competes
   assert_stat_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_func == 3'd0 && wr_addr == 8'h07 && wr_d7 && !evt7)
      |=> !b_stat7);

   // R3: set event always lands
   assert_stat_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt7 |=> b_stat7);

   // R4 R5 R6: segment 0 follows the low code of 0x61 one edge later
   assert_seg0_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_rd0 == $past(b61_lo[1])) && (seg_wr0 == $past(b61_lo[0])));

   // R7: firmware shadow flag tracks the F0000 read bit
   assert_bios_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bios_shadow == $past(b63_f[1])) && (seg_rd_f == $past(b63_f[1])));

   // R8: warm reset removes the F0000 field
   assert_warm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> (b63_f == 2'b00));

   // R9: other functions read as all ones
   assert_func_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_func != 3'd0) |-> (rd_data == 8'hFF));

   // R10: writes to other functions leave the shadow byte alone
   assert_func_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_func != 3'd0 && !warm_rst) |=> $stable(b61_lo));

endmodule

bind hb_shadow_cfg hb_shadow_cfg_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .warm_rst    (warm_rst),
   .wr_en       (wr_en),
   .wr_func     (wr_func),
   .wr_addr     (wr_addr),
   .wr_d7       (wr_data[7]),
   .evt7        (stat_evt[2]),
   .rd_func     (rd_func),
   .rd_data     (rd_data),
   .b_cmd       (cfg_q[4]),
   .b_stat7     (cfg_q[7][7]),
   .b61_lo      (cfg_q[8'h61][1:0]),
   .b63_f       (cfg_q[8'h63][5:4]),
   .seg_rd0     (seg_rd_int[0]),
   .seg_wr0     (seg_wr_int[0]),
   .seg_rd_f    (seg_rd_int[9]),
   .bios_shadow (bios_shadow)
);

// File: tb/hb_shadow_cfg_tb.sv
module hb_shadow_cfg_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       warm_rst = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_func = '0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] stat_evt = '0;
   logic [2:0] rd_func = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [9:0] seg_rd_int;
   logic [9:0] seg_wr_int;
   logic       bios_shadow;

   int checks = 0;
   int fails  = 0;
   logic [7:0] mdl [256];

   always #5 clk = ~clk;

   hb_shadow_cfg dut_i (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en),
      .wr_func(wr_func), .wr_addr(wr_addr), .wr_data(wr_data),
      .stat_evt(stat_evt), .rd_func(rd_func), .rd_addr(rd_addr),
      .rd_data(rd_data), .seg_rd_int(seg_rd_int), .seg_wr_int(seg_wr_int),
      .bios_shadow(bios_shadow)
   );

   function automatic bit tb_ro(int a);
      return a == 0 || a == 1 || (a >= 8 && a <= 12) || a == 14 || a == 15;
   endfunction

   function automatic logic [7:0] tb_rst(int a);
      case (a)
         'h00: return 8'h34;
         'h01: return 8'h12;
         'h04: return 8'h07;
         'h07: return 8'h02;
         'h08: return 8'h02;
         'h0B: return 8'h06;
         'h52: return 8'h02;
         'h58: return 8'h40;
         'h59: return 8'h05;
         'h64: return 8'hAB;
         default: return (a >= 'h5A && a <= 'h5F) ? 8'h01 : 8'h00;
      endcase
   endfunction

   function automatic void tb_apply(int a, logic [7:0] d);
      if (tb_ro(a)) return;
      if (a == 4) mdl[a] = (mdl[a] & 8'hBF) | (d & 8'h40);
      else if (a == 7) mdl[a] = mdl[a] & ~(d & 8'hB0);
      else mdl[a] = d;
   endfunction

   function automatic logic [9:0] exp_vec(bit rd);
      logic [9:0] v;
      int b;
      b = rd ? 1 : 0;
      for (int s = 0; s < 8; s++) begin
         logic [7:0] by;
         by = mdl['h61 + s / 4];
         v[s] = by[(s % 4) * 2 + b];
      end
      v[8] = mdl['h63][6 + b];
      v[9] = mdl['h63][4 + b];
      return v;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [2:0] f, logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_func = f; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (f == 3'd0) tb_apply(int'(a), d);
   endtask

   task automatic read_chk(string req, logic [2:0] f, logic [7:0] a, logic [7:0] e);
      rd_func = f; rd_addr = a;
      #1;
      chk(req, $sformatf("read f%0d @%02h", f, a), 32'(rd_data), 32'(e));
      rd_func = 3'd0;
   endtask

   task automatic route_chk(string req);
      chk(req, "seg_rd_int", 32'(seg_rd_int), 32'(exp_vec(1'b1)));
      chk(req, "seg_wr_int", 32'(seg_wr_int), 32'(exp_vec(1'b0)));
      chk("R7", "bios_shadow", 32'(bios_shadow), 32'(mdl['h63][5]));
   endtask

   task automatic shadow_sweep(logic [7:0] a);
      for (int v = 0; v < 256; v++) begin
         logic [9:0] old_rd;
         logic [9:0] old_wr;
         old_rd = exp_vec(1'b1);
         old_wr = exp_vec(1'b0);
         do_write(3'd0, a, 8'(v));
         chk("R6", "lagged rd", 32'(seg_rd_int), 32'(old_rd));
         chk("R6", "lagged wr", 32'(seg_wr_int), 32'(old_wr));
         @(negedge clk);
         route_chk("R4 R5");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int a = 0; a < 256; a++) mdl[a] = tb_rst(a);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state: R1 R2 R3 R11, routing zero R6
      for (int a = 0; a < 256; a++) read_chk("R1 R2 R3 R11 reset", 3'd0, 8'(a), tb_rst(a));
      chk("R6", "reset rd routes", 32'(seg_rd_int), 32'd0);
      chk("R6", "reset wr routes", 32'(seg_wr_int), 32'd0);
      chk("R7", "reset bios", 32'(bios_shadow), 32'd0);

      // R9: other functions read 0xFF
      for (int f = 1; f < 8; f++) read_chk("R9", 3'(f), 8'(f * 37), 8'hFF);

      // R10: writes to other functions discarded
      for (int f = 1; f < 8; f++) begin
         do_write(3'(f), 8'h61, 8'hFF);
         do_write(3'(f), 8'h20, 8'h5C);
      end
      read_chk("R10", 3'd0, 8'h61, 8'h00);
      read_chk("R10", 3'd0, 8'h20, 8'h00);
      @(negedge clk);
      route_chk("R10");

      // full write sweeps with two patterns: R1 R2 R3 R11
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 256; a++) begin
            logic [7:0] d;
            d = (p == 0) ? (8'(a) ^ 8'h5A) : ~(8'(a) ^ 8'h5A);
            do_write(3'd0, 8'(a), d);
         end
         for (int a = 0; a < 256; a++) read_chk("R1 R2 R3 R11 sweep", 3'd0, 8'(a), mdl[a]);
         @(negedge clk);
         route_chk("R4 R5 sweep");
      end

      // exhaustive shadow codes: R4 R5 R6 R7
      shadow_sweep(8'h61);
      shadow_sweep(8'h62);
      shadow_sweep(8'h63);

      // status bits R3
      @(negedge clk); stat_evt = 3'b111;
      @(negedge clk); stat_evt = 3'b000;
      mdl[7] = mdl[7] | 8'hB0;
      read_chk("R3 set", 3'd0, 8'h07, 8'hB2);
      do_write(3'd0, 8'h07, 8'h10);
      read_chk("R3 clear bit4", 3'd0, 8'h07, 8'hA2);
      do_write(3'd0, 8'h07, 8'h4F);
      read_chk("R3 zeros keep", 3'd0, 8'h07, 8'hA2);
      @(negedge clk);
      stat_evt = 3'b100; wr_en = 1'b1; wr_func = 3'd0; wr_addr = 8'h07; wr_data = 8'hA0;
      @(negedge clk);
      stat_evt = 3'b000; wr_en = 1'b0;
      mdl[7] = 8'h82;
      read_chk("R3 set beats clear", 3'd0, 8'h07, 8'h82);

      // warm reset R8
      do_write(3'd0, 8'h63, 8'hFF);
      do_write(3'd0, 8'h61, 8'hFF);
      do_write(3'd0, 8'h04, 8'h47);
      @(negedge clk);
      route_chk("R8 before");
      warm_rst = 1'b1;
      @(negedge clk);
      warm_rst = 1'b0;
      mdl['h63] = 8'hCF;
      read_chk("R8 clears field", 3'd0, 8'h63, 8'hCF);
      read_chk("R8 others kept", 3'd0, 8'h61, 8'hFF);
      read_chk("R8 others kept", 3'd0, 8'h04, mdl[4]);
      read_chk("R8 others kept", 3'd0, 8'h64, mdl['h64]);
      @(negedge clk);
      route_chk("R8 routes");
      chk("R8", "F0000 read off", 32'(seg_rd_int[9]), 32'd0);
      chk("R8", "E0000 kept", 32'(seg_rd_int[8]), 32'd1);
      @(negedge clk);
      warm_rst = 1'b1; wr_en = 1'b1; wr_func = 3'd0; wr_addr = 8'h63; wr_data = 8'h30;
      @(negedge clk);
      warm_rst = 1'b0; wr_en = 1'b0;
      mdl['h63] = 8'h00;
      read_chk("R8 beats write", 3'd0, 8'h63, 8'h00);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule